// File: doc/BRIEF.md
# Masked Serial Fuse Programming Sequencer

This engine burns one word into a one-time-programmable fuse array. A front end hands it a target word address, a data word and a timing word in a single-cycle request. The engine first reads the fuse word at that address and removes from the request every bit that is already blown. It then walks the remaining word from bit 0 upward. The data register shifts right with zero fill, one position per step. A set bit produces a program strobe and a clear bit is passed over.

The timing word sets three lengths: the program strobe, the relax gap and the read strobe. The relax setting also stretches both strobes by twice the relax count plus one cycle. A relax field of zero is rejected: the engine reports an error and touches no fuse. When a real access ends, `done` pulses for one cycle and `busy` falls. A quiet period of `GAP_CYCLES` cycles then keeps `ready` low, so the front end cannot start another fuse operation. `busy` is not held during this period.

Top module: `fuse_prog_seq`

## Requirements
- R1: During and after reset, with no request, `busy`, `done`, `err`, `fuse_rd_en` and `fuse_pgm_strobe` are 0 and `ready` is 1.
- R2: A request accepted with a relax field (timing bits [15:12]) of zero raises `done` and `err` together on the next cycle. It makes no read, no strobe and no quiet period.
- R3: Each accepted request with nonzero relax drives `fuse_rd_en` high for exactly read(bits [21:16]) + 2*relax + 1 consecutive cycles at the requested address. This happens before any program strobe, and the two strobes are never high together.
- R4: Strobes are issued only for bits that are 1 in the request and 0 in the fuse word read. Afterwards the fuse word equals the old value OR the request.
- R5: Strobed bits come in ascending index order, one strobe per bit. `fuse_pgm_bit` carries the bit index and stays stable through the strobe, and `fuse_addr` stays stable while busy.
- R6: Each program strobe lasts exactly prog(bits [11:0]) + 2*relax + 1 cycles.
- R7: Between two program strobes of one request, the strobe is low for at least relax + 1 cycles.
- R8: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse with `busy` low, and `err` is 0 on a successful request.
- R9: If the masked word is zero, no strobe is issued, but `done` and the quiet period still follow.
- R10: After a successful `done`, `ready` stays low for exactly `GAP_CYCLES` cycles. Requests raised while `ready` is low are ignored: no read, no `busy`.
- R11: Timing bits outside [21:0] have no effect, and the timing word is sampled only at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is high |
| req_addr | input | AW | Target fuse word address |
| req_data | input | DW | Bits to program (1 = blow) |
| timing_word | input | TMG_W | Timing fields: prog [11:0], relax [15:12], read [21:16] |
| ready | output | 1 | Idle and quiet period over |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: request rejected |
| fuse_addr | output | AW | Address to the fuse array |
| fuse_rd_en | output | 1 | Fuse read strobe |
| fuse_rd_data | input | DW | Fuse word at `fuse_addr` |
| fuse_pgm_strobe | output | 1 | Fuse program strobe |
| fuse_pgm_bit | output | $clog2(DW) | Bit index being programmed |

## Verification
The bench builds the block with a 4-bit address and a 20-cycle quiet period. This keeps the gap count and the injection of ignored requests into it short enough to measure exactly. Small timing field values let a full 32-bit word of strobes finish in a few thousand cycles. Relax is also taken to its field maximum of 15, and junk is placed in the unused upper timing bits. This reaches the extremes of the stretch arithmetic and the field decoding.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_MASK,
        S_SHIFT,
        S_STROBE,
        S_RELAX,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/fuse_tmg_decode.sv
module fuse_tmg_decode #(
    parameter int TMG_W = 32,
    parameter int PRG_W = 12,
    parameter int RLX_W = 4,
    parameter int RDS_W = 6,
    parameter int CNT_W = 14
) (
    input  logic [TMG_W-1:0] timing_word,
    output logic [CNT_W-1:0] rd_last,
    output logic [CNT_W-1:0] pgm_last,
    output logic [CNT_W-1:0] rlx_last,
    output logic             relax_ok
);
    localparam int RLX_LSB = PRG_W;
    localparam int RDS_LSB = PRG_W + RLX_W;

    logic [PRG_W-1:0] prg;
    logic [RLX_W-1:0] rlx;
    logic [RDS_W-1:0] rds;
    logic [CNT_W-1:0] stretch;

    always_comb begin
        prg      = timing_word[0 +: PRG_W];
        rlx      = timing_word[RLX_LSB +: RLX_W];
        rds      = timing_word[RDS_LSB +: RDS_W];
        // last-cycle index: base + 2*(relax+1) - 1 cycles, minus one
        stretch  = CNT_W'(rlx) << 1;
        rd_last  = CNT_W'(rds) + stretch;
        pgm_last = CNT_W'(prg) + stretch;
        rlx_last = CNT_W'(rlx);
        relax_ok = (rlx != '0);
    end
endmodule

// File: rtl/fuse_gap_timer.sv
module fuse_gap_timer #(
    parameter int GAP_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int GW = $clog2(GAP_CYCLES + 1) + 1;

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = GW'(GAP_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fuse_prog_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 7,
    parameter int TMG_W      = 32,
    parameter int PRG_W      = 12,
    parameter int RLX_W      = 4,
    parameter int RDS_W      = 6,
    parameter int GAP_CYCLES = 200,
    localparam int IDX_W     = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [TMG_W-1:0] timing_word,
    output logic             ready,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    fuse_addr,
    output logic             fuse_rd_en,
    input  logic [DW-1:0]    fuse_rd_data,
    output logic             fuse_pgm_strobe,
    output logic [IDX_W-1:0] fuse_pgm_bit
);
    localparam int BASE_W = (PRG_W > RDS_W) ? PRG_W : RDS_W;
    localparam int CNT_W  = BASE_W + 2;

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [DW-1:0]    fuse;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             err;
        logic [CNT_W-1:0] rd_last;
        logic [CNT_W-1:0] pgm_last;
        logic [CNT_W-1:0] rlx_last;
    } seq_t;

    seq_t r_q, r_d;

    logic [CNT_W-1:0] dec_rd_last, dec_pgm_last, dec_rlx_last;
    logic             dec_relax_ok;
    logic             gap_active;
    logic             gap_start;
    logic             accept;

    fuse_tmg_decode #(
        .TMG_W (TMG_W),
        .PRG_W (PRG_W),
        .RLX_W (RLX_W),
        .RDS_W (RDS_W),
        .CNT_W (CNT_W)
    ) u_decode (
        .timing_word (timing_word),
        .rd_last     (dec_rd_last),
        .pgm_last    (dec_pgm_last),
        .rlx_last    (dec_rlx_last),
        .relax_ok    (dec_relax_ok)
    );

    fuse_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .active (gap_active)
    );

    assign ready  = (r_q.st == S_IDLE) && !gap_active;
    assign accept = req_valid && ready;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (accept) begin
                    r_d.addr     = req_addr;
                    r_d.data     = req_data;
                    r_d.idx      = '0;
                    r_d.rd_last  = dec_rd_last;
                    r_d.pgm_last = dec_pgm_last;
                    r_d.rlx_last = dec_rlx_last;
                    if (!dec_relax_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_DONE;
                    end else begin
                        r_d.err = 1'b0;
                        r_d.cnt = dec_rd_last;
                        r_d.st  = S_READ;
                    end
                end
            end
            S_READ: begin
                if (r_q.cnt == '0) begin
                    r_d.fuse = fuse_rd_data;
                    r_d.st   = S_MASK;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            S_MASK: begin
                r_d.data = r_q.data & ~r_q.fuse;
                r_d.st   = S_SHIFT;
            end
            S_SHIFT: begin
                if (r_q.data == '0) begin
                    r_d.st = S_DONE;
                end else if (r_q.data[0]) begin
                    r_d.cnt = r_q.pgm_last;
                    r_d.st  = S_STROBE;
                end else begin
                    r_d.data = r_q.data >> 1;
                    r_d.idx  = r_q.idx + 1'b1;
                end
            end
            S_STROBE: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = r_q.rlx_last;
                    r_d.st  = S_RELAX;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            S_RELAX: begin
                if (r_q.cnt == '0) begin
                    r_d.data = r_q.data >> 1;
                    r_d.idx  = r_q.idx + 1'b1;
                    r_d.st   = S_SHIFT;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign gap_start       = (r_q.st == S_DONE) && !r_q.err;
    assign busy            = (r_q.st != S_IDLE) && (r_q.st != S_DONE);
    assign done            = (r_q.st == S_DONE);
    assign err             = (r_q.st == S_DONE) && r_q.err;
    assign fuse_addr       = r_q.addr;
    assign fuse_rd_en      = (r_q.st == S_READ);
    assign fuse_pgm_strobe = (r_q.st == S_STROBE);
    assign fuse_pgm_bit    = r_q.idx;
endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
    parameter int AW    = 7,
    parameter int TMG_W = 32,
    parameter int PRG_W = 12,
    parameter int RLX_W = 4,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [TMG_W-1:0] timing_word,
    input logic             ready,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [AW-1:0]    fuse_addr,
    input logic             fuse_rd_en,
    input logic             fuse_pgm_strobe,
    input logic [IDX_W-1:0] fuse_pgm_bit
);
    // R2
    relax_zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && timing_word[PRG_W +: RLX_W] == '0) |=> (done && err));

    // R2
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R3
    rd_pgm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_en && fuse_pgm_strobe));

    // R5
    bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgm_strobe && $past(fuse_pgm_strobe)) |-> $stable(fuse_pgm_bit));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fuse_addr));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |=> !ready);
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(
    .AW    (AW),
    .TMG_W (TMG_W),
    .PRG_W (PRG_W),
    .RLX_W (RLX_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .timing_word     (timing_word),
    .ready           (ready),
    .busy            (busy),
    .done            (done),
    .err             (err),
    .fuse_addr       (fuse_addr),
    .fuse_rd_en      (fuse_rd_en),
    .fuse_pgm_strobe (fuse_pgm_strobe),
    .fuse_pgm_bit    (fuse_pgm_bit)
);

// File: tb/tb_fuse_prog_seq.sv
module tb_fuse_prog_seq;
    localparam int AW  = 4;
    localparam int DW  = 32;
    localparam int GAP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [31:0]   timing_word = '0;
    logic          ready, busy, done, err;
    logic [AW-1:0] fuse_addr;
    logic          fuse_rd_en, fuse_pgm_strobe;
    logic [DW-1:0] fuse_rd_data;
    logic [4:0]    fuse_pgm_bit;

    always #5 clk = ~clk;

    fuse_prog_seq #(.DW(DW), .AW(AW), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .timing_word(timing_word), .ready(ready),
        .busy(busy), .done(done), .err(err), .fuse_addr(fuse_addr),
        .fuse_rd_en(fuse_rd_en), .fuse_rd_data(fuse_rd_data),
        .fuse_pgm_strobe(fuse_pgm_strobe), .fuse_pgm_bit(fuse_pgm_bit)
    );

    // behavioural fuse array
    logic [DW-1:0] fmem [2**AW];
    assign fuse_rd_data = fmem[fuse_addr];
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2**AW; i++) fmem[i] <= '0;
        end else if (fuse_pgm_strobe) begin
            fmem[fuse_addr][fuse_pgm_bit] <= 1'b1;
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic check(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // scoreboard state
    int q_bit[$];
    int exp_pw, exp_rw, exp_gap_min, exp_addr;
    bit first_in_op;
    int rd_pulses = 0, pgm_pulses = 0;
    int run = 0, low_run = 0, rd_run = 0, last_bit = 0;
    bit prev_s = 0, prev_rd = 0;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fuse_pgm_strobe) begin
                if (!prev_s && !first_in_op)
                    check(low_run >= exp_gap_min, "R7", "strobe low gap", low_run, exp_gap_min);
                if (!prev_s) begin
                    first_in_op = 0;
                    check(fuse_addr == AW'(exp_addr), "R5", "strobe address", fuse_addr, exp_addr);
                end
                run++;
                last_bit = fuse_pgm_bit;
                low_run = 0;
            end else begin
                low_run++;
                if (prev_s) begin
                    pgm_pulses++;
                    if (q_bit.size() == 0) begin
                        check(0, "R4", "unexpected strobe bit", last_bit, -1);
                    end else begin
                        int eb;
                        eb = q_bit.pop_front();
                        check(last_bit == eb, "R5", "strobe bit order", last_bit, eb);
                    end
                    check(run == exp_pw, "R6", "strobe width", run, exp_pw);
                    run = 0;
                end
            end
            if (fuse_rd_en) begin
                rd_run++;
                check(fuse_addr == AW'(exp_addr), "R3", "read address", fuse_addr, exp_addr);
            end else if (prev_rd) begin
                rd_pulses++;
                check(rd_run == exp_rw, "R3", "read width", rd_run, exp_rw);
                rd_run = 0;
            end
            prev_s  = fuse_pgm_strobe;
            prev_rd = fuse_rd_en;
        end
    end

    function automatic logic [31:0] tw(int prg, int rlx, int rds, logic [31:0] junk);
        return (junk & 32'hFFC0_0000) | 32'(rds << 16) | 32'(rlx << 12) | 32'(prg);
    endfunction

    // driver: one request, full completion and quiet-period checks
    task automatic run_op(int addr, logic [31:0] data, int prg, int rlx, int rds,
                          logic [31:0] junk, string rq);
        logic [31:0] old, masked;
        int rd0, p0, cnt;
        bit bad;
        bad = (rlx == 0);
        @(negedge clk);
        while (!ready) @(negedge clk);
        old    = fmem[addr];
        masked = bad ? 32'h0 : (data & ~old);
        for (int b = 0; b < 32; b++) if (masked[b]) q_bit.push_back(b);
        exp_pw = prg + 2*rlx + 1;
        exp_rw = rds + 2*rlx + 1;
        exp_gap_min = rlx + 1;
        exp_addr = addr;
        first_in_op = 1;
        rd0 = rd_pulses;
        p0  = pgm_pulses;
        req_valid   = 1'b1;
        req_addr    = AW'(addr);
        req_data    = data;
        timing_word = tw(prg, rlx, rds, junk);
        @(negedge clk);
        req_valid   = 1'b0;
        timing_word = 32'hFFFF_FFFF;   // R11: changes after acceptance must not matter
        if (bad) begin
            check(done && err, "R2", "done+err after relax zero", {done, err}, 2'b11);
        end else begin
            check(busy, "R8", "busy after accept", busy, 1);
            cnt = 0;
            while (!done && cnt < 5000) begin @(negedge clk); cnt++; end
            check(busy == 0, "R8", "busy low at done", busy, 0);
            check(err == 0, "R8", "err on success", err, 0);
        end
        check(q_bit.size() == 0, rq, "missing strobes", q_bit.size(), 0);
        q_bit.delete();
        check(fmem[addr] == (bad ? old : (old | data)), rq, "fuse word", fmem[addr],
              bad ? old : (old | data));
        check(rd_pulses - rd0 == (bad ? 0 : 1), bad ? "R2" : "R3", "read count",
              rd_pulses - rd0, bad ? 0 : 1);
        check(pgm_pulses - p0 == $countones(masked), rq, "strobe count",
              pgm_pulses - p0, $countones(masked));
        // quiet period
        @(negedge clk);
        check(done == 0, "R8", "done one cycle", done, 0);
        rd0 = rd_pulses;
        cnt = 0;
        while (!ready && cnt < GAP + 5) begin
            req_valid = (cnt == 3);
            cnt++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(cnt == (bad ? 0 : GAP), bad ? "R2" : "R10", "quiet cycles", cnt, bad ? 0 : GAP);
        check(busy == 0 && rd_pulses == rd0 && !fuse_rd_en, "R10", "request during gap ignored",
              {busy, fuse_rd_en}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !fuse_rd_en && !fuse_pgm_strobe && ready,
              "R1", "outputs in reset", {busy, done, err, fuse_rd_en, fuse_pgm_strobe, ready}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && ready, "R1", "idle after reset", {busy, done, ready}, 1);

        run_op(3, 32'h0000_00A5, 5, 2, 3, 32'h0, "R4");          // fresh word
        run_op(3, 32'h0000_00FF, 5, 2, 3, 32'h0, "R4");          // partial mask
        run_op(3, 32'h0000_00A5, 5, 2, 3, 32'h0, "R9");          // fully masked
        run_op(5, 32'h0000_0000, 2, 1, 0, 32'h0, "R9");          // empty request
        run_op(6, 32'h8000_0001, 3, 1, 2, 32'hFFC0_0000, "R11"); // junk upper bits
        run_op(7, 32'hFFFF_FFFF, 5, 0, 3, 32'h0, "R2");          // relax zero
        run_op(7, 32'hFFFF_FFFF, 1, 15, 0, 32'h0, "R6");         // max relax, all bits
        run_op(9, 32'h0F0F_1234, 0, 3, 63, 32'h0, "R5");         // max read field

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule